// File: doc/BRIEF.md
# Single-channel DMA transfer engine

This block copies a programmed run of items from one bus address to another as a bus master, so that a processor does not have to touch each item. Software supplies a source, a destination, an item count, an item width and a transfer mode, then pulses a start strobe. The engine requests the shared bus and, once it is granted, carries out each beat as a single read followed by a single write. A beat stays on the bus until the target stops inserting wait states.

Three modes are available. Memory-to-memory copies run beat after beat while the engine keeps the bus. Peripheral-to-memory transfers read from one fixed register address and fill a buffer. Memory-to-peripheral transfers drain a buffer into one fixed register address. Both peripheral modes are paced by a request line, with one beat per request, and the engine hands the bus back after every beat. When the last item has been written, a sticky completion flag is set and a one-cycle interrupt pulse is issued. Byte lanes follow the low address bits, so items narrower than the bus land on the correct lanes.

Top module: `dma_engine`

## Requirements
- R1: Width code 0, 1 and 2 selects items of 1, 2 and 4 bytes. Each read or write drives byte enables for exactly that many lanes, starting at lane `addr[1:0]`. A transfer makes exactly count read/write beat pairs.
- R2: Mode 2'b00 (memory-to-memory) adds the item size to both the source and the destination address after every beat.
- R3: Mode 2'b01 (peripheral-to-memory) keeps the source address fixed and adds the item size to the destination address after every beat.
- R4: Mode 2'b10 (memory-to-peripheral) adds the item size to the source address after every beat and keeps the destination address fixed.
- R5: A start with mode 2'b11 or width code 3 sets `cfg_err`, leaves `busy` low and makes no bus request. The next valid start clears `cfg_err`.
- R6: A valid start with a count of zero makes no bus request. It sets `done`, and `irq` is high in the following cycle.
- R7: A start strobe that arrives while `busy` is high is ignored: the running transfer keeps its configuration and its beat count.
- R8: In the peripheral modes, each rising edge of `per_req` allows exactly one beat, and a level held high counts only once. `bus_req` goes low in the cycle after each beat's write completes.
- R9: In memory-to-memory mode, `bus_req` stays high between beats, and the next read is driven in the cycle right after a write completes.
- R10: While `bus_wait` is high, an active read or write keeps its strobe, address and byte enables unchanged.
- R11: The cycle after the last write completes, `busy` is low, `done` is high and `irq` is high for exactly one cycle. `done` stays high until the next accepted valid start with a nonzero count.
- R12: The first read of a bus tenure is driven only after `bus_gnt` has been seen with `bus_req` high.
- R13: The data written in each beat is the item that was read, taken from the source lanes and placed on the destination lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Start strobe, sampled while idle |
| cfg_mode | input | 2 | 00 mem-to-mem, 01 periph-to-mem, 10 mem-to-periph, 11 invalid |
| cfg_width | input | 2 | Item width code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 invalid |
| cfg_count | input | CNT_W | Number of items |
| cfg_src | input | ADDR_W | Source byte address |
| cfg_dst | input | ADDR_W | Destination byte address |
| per_req | input | 1 | Peripheral beat request |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | ADDR_W | Byte address of the current access |
| bus_be | output | DATA_W/8 | Byte lane enables |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid when a read has no wait |
| bus_wait | input | 1 | Wait-state request from the target |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion interrupt |
| cfg_err | output | 1 | Last start was rejected |

## Verification
The assertions rely on three things about the environment. A grant, once given, stays asserted for as long as `bus_req` is high. `bus_wait` always drops low again after a few cycles. Addresses are aligned to the item width, so that no item crosses a bus word. The stimulus grants only while a request is up and keeps the grant until the request falls. Its wait pattern repeats every four cycles with two free cycles in each period, and every address it programs is a multiple of the item size. It also never lets more than three unserved peripheral requests build up.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [1:0] MODE_M2M = 2'b00;
  localparam logic [1:0] MODE_P2M = 2'b01;
  localparam logic [1:0] MODE_M2P = 2'b10;
  localparam logic [1:0] MODE_BAD = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PACE,
    ST_ARB,
    ST_RD,
    ST_WR
  } beat_state_e;

  function automatic logic [2:0] item_bytes(input logic [1:0] wcode);
    case (wcode)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic cfg_ok(input logic [1:0] mode, input logic [1:0] wcode);
    return (mode != MODE_BAD) && (wcode != 2'd3);
  endfunction

  function automatic logic src_moves(input logic [1:0] mode);
    return mode != MODE_P2M;
  endfunction

  function automatic logic dst_moves(input logic [1:0] mode);
    return mode != MODE_M2P;
  endfunction
endpackage

// File: rtl/dma_req_track.sv
module dma_req_track #(
  parameter int PEND_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic per_req,
  input  logic take,
  output logic has_req
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic              req_q;
  logic [PEND_W-1:0] pend_q;
  logic              rise;

  assign rise    = per_req & ~req_q;
  assign has_req = pend_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= '0;
    end else begin
      req_q <= per_req;
      if (clear)
        pend_q <= '0;
      else if (rise && !take && pend_q != PEND_MAX)
        pend_q <= pend_q + 1'b1;
      else if (take && !rise)
        pend_q <= pend_q - 1'b1;
    end
  end

  // R8: a beat is only taken against a recorded request
  a_r8_take_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> has_req);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [1:0]        cfg_width,
  input  logic [1:0]        cfg_mode,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [1:0]        width_q,
  output logic [1:0]        mode_q,
  output logic              last_item
);
  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] stride;

  assign stride    = ADDR_W'(item_bytes(width_q));
  assign last_item = left_q == CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      left_q  <= '0;
      width_q <= 2'd0;
      mode_q  <= MODE_M2M;
    end else if (load) begin
      src_q   <= cfg_src;
      dst_q   <= cfg_dst;
      left_q  <= cfg_count;
      width_q <= cfg_width;
      mode_q  <= cfg_mode;
    end else if (step) begin
      if (src_moves(mode_q)) src_q <= src_q + stride;
      if (dst_moves(mode_q)) dst_q <= dst_q + stride;
      left_q <= left_q - 1'b1;
    end
  end

  a_r2_both_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode_q == MODE_M2M) |=>
      (src_q == $past(src_q) + $past(stride)) && (dst_q == $past(dst_q) + $past(stride)));
  a_r3_src_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode_q == MODE_P2M) |=> $stable(src_q) && (dst_q == $past(dst_q) + $past(stride)));
  a_r4_dst_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode_q == MODE_M2P) |=> $stable(dst_q) && (src_q == $past(src_q) + $past(stride)));
endmodule

// File: rtl/dma_lane_align.sv
module dma_lane_align
  import dma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]                     width_q,
  input  logic [$clog2(DATA_W/8)-1:0]    src_off,
  input  logic [$clog2(DATA_W/8)-1:0]    dst_off,
  input  logic [DATA_W-1:0]              bus_rdata,
  input  logic [DATA_W-1:0]              item_q,
  output logic [DATA_W/8-1:0]            rd_be,
  output logic [DATA_W/8-1:0]            wr_be,
  output logic [DATA_W-1:0]              rd_item,
  output logic [DATA_W-1:0]              wr_data
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  function automatic logic [LANES-1:0] lanes_for(input logic [1:0] w,
                                                 input logic [OFF_W-1:0] off);
    logic [LANES-1:0] base;
    base = '0;
    for (int i = 0; i < LANES; i++)
      if (i < int'(item_bytes(w))) base[i] = 1'b1;
    return base << off;
  endfunction

  function automatic logic [DATA_W-1:0] item_mask(input logic [1:0] w);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++)
      if (i < int'(item_bytes(w))) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  assign rd_be   = lanes_for(width_q, src_off);
  assign wr_be   = lanes_for(width_q, dst_off);
  assign rd_item = (bus_rdata >> {src_off, 3'b000}) & item_mask(width_q);
  assign wr_data = item_q << {dst_off, 3'b000};
endmodule

// File: rtl/dma_beat_ctl.sv
module dma_beat_ctl
  import dma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_count_zero,
  input  logic [1:0]        mode_q,
  input  logic              last_item,
  input  logic              has_req,
  input  logic              bus_gnt,
  input  logic              bus_wait,
  input  logic [DATA_W-1:0] rd_item,
  output logic              load,
  output logic              take,
  output logic              rd_fire,
  output logic              wr_fire,
  output logic [DATA_W-1:0] item_q,
  output logic              bus_req,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic              cfg_err
);
  beat_state_e st, nxt;
  logic accept, good, empty_ok, finish, paced;

  assign accept   = (st == ST_IDLE) && cfg_start;
  assign good     = cfg_ok(cfg_mode, cfg_width);
  assign empty_ok = accept && good && cfg_count_zero;
  assign load     = accept && good && !cfg_count_zero;
  assign take     = (st == ST_PACE) && has_req;
  assign rd_fire  = (st == ST_RD) && !bus_wait;
  assign wr_fire  = (st == ST_WR) && !bus_wait;
  assign finish   = wr_fire && last_item;
  assign paced    = mode_q != MODE_M2M;

  assign bus_req = (st == ST_ARB) || (st == ST_RD) || (st == ST_WR);
  assign bus_rd  = st == ST_RD;
  assign bus_wr  = st == ST_WR;
  assign busy    = st != ST_IDLE;

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE: if (load) nxt = (cfg_mode == MODE_M2M) ? ST_ARB : ST_PACE;
      ST_PACE: if (take) nxt = ST_ARB;
      ST_ARB:  if (bus_gnt) nxt = ST_RD;
      ST_RD:   if (rd_fire) nxt = ST_WR;
      ST_WR:   if (wr_fire) nxt = finish ? ST_IDLE : (paced ? ST_PACE : ST_RD);
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      item_q  <= '0;
      done    <= 1'b0;
      irq     <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      st  <= nxt;
      irq <= finish || empty_ok;
      if (rd_fire) item_q <= rd_item;
      if (load) done <= 1'b0;
      else if (finish || empty_ok) done <= 1'b1;
      if (accept) cfg_err <= !good;
    end
  end

  a_r5_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy && !bus_req);
  a_r6_empty_irq: assert property (@(posedge clk) disable iff (!rst_n)
    empty_ok |=> irq && done && !bus_req);
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && paced) |=> !bus_req);
  a_r9_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !paced && !last_item) |=> bus_rd && bus_req);
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wait) |=> bus_rd);
  a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wait) |=> bus_wr);
  a_r11_irq_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done && !busy);
  a_r12_no_gnt_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARB && !bus_gnt) |=> !bus_rd);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PEND_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_start,
  input  logic [1:0]          cfg_mode,
  input  logic [1:0]          cfg_width,
  input  logic [CNT_W-1:0]    cfg_count,
  input  logic [ADDR_W-1:0]   cfg_src,
  input  logic [ADDR_W-1:0]   cfg_dst,
  input  logic                per_req,
  output logic                bus_req,
  input  logic                bus_gnt,
  output logic                bus_rd,
  output logic                bus_wr,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata,
  input  logic                bus_wait,
  output logic                busy,
  output logic                done,
  output logic                irq,
  output logic                cfg_err
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic              load, take, rd_fire, wr_fire, has_req, last_item;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [1:0]        width_q, mode_q;
  logic [DATA_W-1:0] item_q, rd_item, wr_data;
  logic [LANES-1:0]  rd_be, wr_be;

  dma_req_track #(.PEND_W(PEND_W)) u_req (
    .clk(clk), .rst_n(rst_n), .clear(load), .per_req(per_req),
    .take(take), .has_req(has_req)
  );

  dma_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(wr_fire),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
    .cfg_width(cfg_width), .cfg_mode(cfg_mode),
    .src_q(src_q), .dst_q(dst_q), .width_q(width_q), .mode_q(mode_q),
    .last_item(last_item)
  );

  dma_lane_align #(.DATA_W(DATA_W)) u_lane (
    .width_q(width_q), .src_off(src_q[OFF_W-1:0]), .dst_off(dst_q[OFF_W-1:0]),
    .bus_rdata(bus_rdata), .item_q(item_q),
    .rd_be(rd_be), .wr_be(wr_be), .rd_item(rd_item), .wr_data(wr_data)
  );

  dma_beat_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
    .cfg_width(cfg_width), .cfg_count_zero(cfg_count == '0),
    .mode_q(mode_q), .last_item(last_item), .has_req(has_req),
    .bus_gnt(bus_gnt), .bus_wait(bus_wait), .rd_item(rd_item),
    .load(load), .take(take), .rd_fire(rd_fire), .wr_fire(wr_fire),
    .item_q(item_q), .bus_req(bus_req), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .busy(busy), .done(done), .irq(irq), .cfg_err(cfg_err)
  );

  assign bus_addr  = bus_wr ? dst_q : src_q;
  assign bus_be    = bus_wr ? wr_be : (bus_rd ? rd_be : '0);
  assign bus_wdata = bus_wr ? wr_data : '0;

  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && bus_wait) |=> $stable(bus_addr) && $stable(bus_be));
  a_r12_rd_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !$past(bus_rd) && !$past(bus_wr)) |-> $past(bus_gnt) && $past(bus_req));
  a_r1_be_count: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> $countones(bus_be) == int'(item_bytes(width_q)));
endmodule

// File: tb/test_dma_engine.sv
module test_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_start = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [1:0]  cfg_width = 2'd0;
  logic [15:0] cfg_count = '0;
  logic [31:0] cfg_src = '0;
  logic [31:0] cfg_dst = '0;
  logic        per_req = 1'b0;
  logic        bus_req, bus_rd, bus_wr, busy, done, irq, cfg_err;
  logic        bus_gnt = 1'b0;
  logic        bus_wait = 1'b0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  bus_be;

  always #4 clk = ~clk;

  dma_engine i_dma_engine (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
    .cfg_width(cfg_width), .cfg_count(cfg_count), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .per_req(per_req), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
    .busy(busy), .done(done), .irq(irq), .cfg_err(cfg_err)
  );

  logic [7:0] mem  [0:255];
  logic [7:0] gold [0:255];
  int n_chk = 0, n_fail = 0, n_wr = 0, cyc = 0;
  bit wait_en = 1'b0, finished = 1'b0;

  assign bus_rdata = {mem[{bus_addr[7:2], 2'd3}], mem[{bus_addr[7:2], 2'd2}],
                      mem[{bus_addr[7:2], 2'd1}], mem[{bus_addr[7:2], 2'd0}]};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int wbytes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [3:0] lanes(input int w, input int off);
    return 4'(((1 << w) - 1) << off);
  endfunction

  // Reference model state
  int          m_ph = 0, m_left = 0, m_w = 1, m_pend = 0;
  logic [1:0]  m_mode = 2'd0;
  logic [31:0] m_src = '0, m_dst = '0, m_hold = '0;
  bit          m_done = 0, m_irq = 0, m_err = 0, m_prev = 0;

  function automatic string addr_tag(input logic [1:0] md);
    return (md == 2'd0) ? "R2 address" : (md == 2'd1) ? "R3 address" : "R4 address";
  endfunction

  initial forever begin
    @(negedge clk);
    cyc++;
    bus_gnt  = bus_req && (bus_gnt || (cyc % 3 == 0));
    bus_wait = wait_en && (bus_rd || bus_wr) && ((cyc % 4 == 1) || (cyc % 4 == 2));
    #2;
    if (!rst_n) begin
      m_ph = 0; m_pend = 0; m_done = 0; m_irq = 0; m_err = 0; m_prev = 0;
    end else begin
      bit rise, take, loaded, nirq;
      chk("R7 busy", busy, m_ph != 0);
      chk("R11 done", done, m_done);
      chk("R11 irq", irq, m_irq);
      chk("R5 cfg_err", cfg_err, m_err);
      chk("R8 bus_req", bus_req, m_ph >= 2);
      chk("R10 bus_rd", bus_rd, m_ph == 3);
      chk("R10 bus_wr", bus_wr, m_ph == 4);
      if (m_ph == 3) begin
        chk(addr_tag(m_mode), bus_addr, m_src);
        chk("R1 read lanes", bus_be, lanes(m_w, m_src % 4));
      end else if (m_ph == 4) begin
        chk(addr_tag(m_mode), bus_addr, m_dst);
        chk("R1 write lanes", bus_be, lanes(m_w, m_dst % 4));
        chk("R13 write data", bus_wdata, m_hold << (8 * (m_dst % 4)));
      end else begin
        chk("R1 idle lanes", bus_be, 4'd0);
      end
      if (bus_wr && !bus_wait) begin
        n_wr++;
        for (int b = 0; b < 4; b++)
          if (bus_be[b]) mem[{bus_addr[7:2], 2'(b)}] = bus_wdata[8*b +: 8];
      end
      rise = per_req && !m_prev;
      take = (m_ph == 1) && (m_pend > 0);
      loaded = 0; nirq = 0;
      case (m_ph)
        0: if (cfg_start) begin
             if (cfg_mode == 2'b11 || cfg_width == 2'd3) m_err = 1;
             else begin
               m_err = 0;
               if (cfg_count == 0) begin m_done = 1; nirq = 1; end
               else begin
                 loaded = 1; m_done = 0; m_mode = cfg_mode; m_w = wbytes(cfg_width);
                 m_src = cfg_src; m_dst = cfg_dst; m_left = cfg_count;
                 m_ph = (cfg_mode == 2'd0) ? 2 : 1;
               end
             end
           end
        1: if (take) m_ph = 2;
        2: if (bus_gnt) m_ph = 3;
        3: if (!bus_wait) begin
             m_hold = (bus_rdata >> (8 * (m_src % 4))) &
                      ((m_w == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * m_w)) - 1));
             m_ph = 4;
           end
        default: if (!bus_wait) begin
             if (m_mode != 2'd1) m_src = m_src + m_w;
             if (m_mode != 2'd2) m_dst = m_dst + m_w;
             m_left--;
             if (m_left == 0) begin m_ph = 0; m_done = 1; nirq = 1; end
             else m_ph = (m_mode == 2'd0) ? 3 : 1;
           end
      endcase
      if (loaded) m_pend = 0;
      else if (rise && !take && m_pend < 3) m_pend++;
      else if (take && !rise) m_pend--;
      m_irq = nirq;
      m_prev = per_req;
    end
  end

  task automatic start(input logic [1:0] md, input logic [1:0] wc, input int cnt,
                       input int s, input int d, input bit upd_gold);
    @(negedge clk); #1;
    cfg_mode = md; cfg_width = wc; cfg_count = 16'(cnt);
    cfg_src = 32'(s); cfg_dst = 32'(d); cfg_start = 1'b1;
    if (upd_gold) begin
      int w;
      w = wbytes(wc);
      for (int k = 0; k < cnt; k++)
        for (int b = 0; b < w; b++) begin
          int si, di;
          si = (md == 2'd1) ? s + b : s + k * w + b;
          di = (md == 2'd2) ? d + b : d + k * w + b;
          gold[di] = gold[si];
        end
    end
    @(negedge clk); #1;
    cfg_start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    @(negedge clk); #1;
  endtask

  task automatic pulse_req(input int gap);
    @(negedge clk); #1 per_req = 1'b1;
    @(negedge clk); #1 per_req = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic mem_check(input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== gold[i]) bad++;
    chk(tag, 32'(bad), 32'd0);
  endtask

  initial begin
    int wr0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 11);
      gold[i] = 8'(i * 37 + 11);
    end
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #3;
    chk("R11 reset done", done, 0);
    chk("R8 reset bus_req", bus_req, 0);
    chk("R7 reset busy", busy, 0);

    // R2 R9 R13: word copy, no waits
    wr0 = n_wr;
    start(2'd0, 2'd2, 4, 'h00, 'h40, 1);
    wait_idle();
    mem_check("R2 word copy contents");
    chk("R1 word copy beat count", 32'(n_wr - wr0), 4);

    // R1 R10: byte copy with wait states, odd lanes
    wait_en = 1'b1;
    wr0 = n_wr;
    start(2'd0, 2'd0, 6, 'h11, 'h82, 1);
    wait_idle();
    mem_check("R1 byte copy contents");
    chk("R1 byte copy beat count", 32'(n_wr - wr0), 6);

    // R7: halfword copy, second start while busy is ignored
    wr0 = n_wr;
    start(2'd0, 2'd1, 3, 'h22, 'hC4, 1);
    repeat (2) @(negedge clk);
    start(2'd2, 2'd2, 1, 'h00, 'hFC, 0);
    wait_idle();
    mem_check("R7 ignored start contents");
    chk("R7 beat count kept", 32'(n_wr - wr0), 3);

    // R3 R8: peripheral to memory, paced by pulses
    wr0 = n_wr;
    start(2'd1, 2'd1, 4, 'h30, 'h50, 1);
    repeat (4) pulse_req(7);
    wait_idle();
    mem_check("R3 periph-to-mem contents");
    chk("R8 paced beat count", 32'(n_wr - wr0), 4);

    // R4: memory to peripheral
    start(2'd2, 2'd2, 3, 'h60, 'hF0, 1);
    repeat (3) pulse_req(7);
    wait_idle();
    mem_check("R4 mem-to-periph contents");
    chk("R11 done after mem-to-periph", done, 1);

    // R8: held request counts once
    wr0 = n_wr;
    start(2'd1, 2'd0, 3, 'h34, 'hA0, 1);
    @(negedge clk); #1 per_req = 1'b1;
    repeat (14) @(negedge clk);
    chk("R8 held level one beat", 32'(n_wr - wr0), 1);
    chk("R8 bus released while held", bus_req, 0);
    #1 per_req = 1'b0;
    repeat (2) pulse_req(7);
    wait_idle();
    mem_check("R8 held level contents");

    // R5: bad mode and bad width
    start(2'd3, 2'd0, 2, 'h00, 'h10, 0);
    repeat (4) @(negedge clk); #3;
    chk("R5 bad mode flagged", cfg_err, 1);
    chk("R5 bad mode no busy", busy, 0);
    start(2'd0, 2'd3, 2, 'h00, 'h10, 0);
    #1;
    chk("R5 bad width flagged", cfg_err, 1);
    chk("R5 bad width no request", bus_req, 0);
    mem_check("R5 no writes after rejects");

    // R6: zero count
    start(2'd0, 2'd2, 0, 'h00, 'h10, 0);
    #1;
    chk("R6 irq after empty", irq, 1);
    chk("R6 done after empty", done, 1);
    chk("R5 err cleared by valid start", cfg_err, 0);
    @(negedge clk); #3;
    chk("R6 irq one cycle", irq, 0);
    chk("R6 no request", bus_req, 0);

    // R12 R9: memory copy with waits, grant latency
    start(2'd0, 2'd2, 5, 'h80, 'hE0, 1);
    wait_idle();
    mem_check("R12 final copy contents");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete (R11)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule